// File: doc/BRIEF.md
# Serial Channel with Control Register

This block is one asynchronous serial channel. It has a transmitter, a receiver, a small FIFO on each side and a register port. The register port is a simple synchronous read/write bus. Through it software sets the control word and the baud divisor, writes characters to send, reads received characters and reads sticky error flags. The channel has three interrupt outputs: transmit, receive and error. The baud clock source is one of three tick-enable inputs, chosen by a control field. The selected source is divided by `DIV+1` to give a sample tick at sixteen times the bit rate. Characters are fixed at 8 data bits, no parity and 1 stop bit, sent LSB first.

Registers: offset 0 is the control word CTRL, offset 1 is the divisor DIV, offset 2 is DATA (a write pushes a character to the transmit side, a read pops one from the receive side), and offset 3 is the status word STAT. CTRL bits: [11:10] clock source, [9] transmit interrupt style, [8] receive interrupt style, [7] receive time-out enable, [6] error interrupt enable, [5] loopback, [4] send break, [0] FIFO enable. Bits [3:1] are stored and read back with no effect. STAT bits: [0] receive data present, [1] transmitter empty (FIFO empty and shifter idle), [2] overrun, [3] framing error, [4] break. A read of STAT clears bits [4:2].

Transmitter states and transitions:
- T_IDLE goes to T_BREAK when a break is requested. Otherwise it goes to T_START when a character is waiting.
- T_START goes to T_DATA after one bit time.
- T_DATA goes to T_STOP after the eighth bit.
- T_STOP goes to T_IDLE after one bit time.
- T_BREAK goes to T_IDLE after ten bit times.

Receiver states and transitions:
- R_IDLE goes to R_START when the line is low at a sample tick.
- R_START goes to R_DATA if the line is still low at half a bit. Otherwise it goes back to R_IDLE.
- R_DATA goes to R_STOP after eight samples.
- R_STOP goes to R_IDLE when the stop bit is high. Otherwise it goes to R_WAITHI.
- R_WAITHI goes to R_IDLE once the line is high.

Top module: `uart_chan`

## Requirements
- R1: After reset the register values are CTRL = 0x0000 and STAT = 0x0002. The tx line is high and all three interrupt outputs are low.
- R2: CTRL[11:10] selects the tick source: 00 and 10 select `pclk_en`, 01 selects `ext_en`, 11 selects `pll_en`. One bit lasts 16 × (DIV+1) selected ticks. Unselected sources have no effect.
- R3: A written character is sent as a low start bit, then 8 data bits LSB first, then a high stop bit.
- R4: A well-formed 8N1 character on `rx_i` is returned by a read of DATA (offset 2), in arrival order.
- R5: With CTRL[9]=0, `tx_irq_o` is a one-cycle pulse. It fires when the transmit buffer becomes empty (non-FIFO mode) or when the transmit FIFO count drops to TX_TRIG (FIFO mode). With CTRL[9]=1 it is a level that stays high while that condition holds.
- R6: With CTRL[8]=0, `rx_irq_o` is a one-cycle pulse. It fires when a character lands in the receive buffer (non-FIFO mode) or when the receive FIFO count reaches RX_TRIG (FIFO mode). With CTRL[8]=1 it is a level.
- R7: With CTRL[7]=1 and FIFO mode on, a non-empty receive FIFO with no new character for TO_CHARS character times (160 sample ticks each) raises a receive interrupt. A DATA read clears it. In non-FIFO mode CTRL[7] has no effect.
- R8: With CTRL[6]=1, `err_irq_o` pulses for one cycle on a break, a framing error (stop bit low, data not zero) or an overrun. STAT[3] records a framing error.
- R9: A character that completes while the receive buffer is full is dropped. STAT[2] is then set and holds until STAT is read.
- R10: A frame that stays low through its stop bit, with all-zero data, sets STAT[4]. No character is stored.
- R11: With CTRL[5]=1 the transmitter output drives the receiver, `rx_i` is ignored and `tx_o` stays high.
- R12: Setting CTRL[4] holds `tx_o` low for exactly 160 sample ticks. The channel then clears CTRL[4] by itself.
- R13: With CTRL[0]=1 each FIFO holds DEPTH characters. With CTRL[0]=0 each side holds one character, so a second unread receive character overruns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pclk_en | input | 1 | Peripheral clock tick enable |
| ext_en | input | 1 | External serial clock tick enable |
| pll_en | input | 1 | Divided PLL clock tick enable |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after `rd_i` |
| rx_i | input | 1 | Serial input |
| tx_o | output | 1 | Serial output |
| tx_irq_o | output | 1 | Transmit interrupt |
| rx_irq_o | output | 1 | Receive interrupt |
| err_irq_o | output | 1 | Receive error interrupt |

## Verification
The bench builds the channel with DEPTH=4, TX_TRIG=1, RX_TRIG=2 and TO_CHARS=3. With these values, five back-to-back characters overrun the receive FIFO, and the receive trigger is crossed by the second character. The time-out fires within about 500 cycles. The divisor is mostly 0 with `pclk_en` held high, so one bit is 16 cycles and a break is exactly 160 cycles. One pass sets DIV=1 on the PLL source to check the 32-cycle bit.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
    typedef enum logic [1:0] {A_CTRL = 2'd0, A_DIV = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3} addr_e;
    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_STOP, T_BREAK} tx_st_e;
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP, R_WAITHI} rx_st_e;
    localparam int CB_FIFO  = 0;
    localparam int CB_BRK   = 4;
    localparam int CB_LOOP  = 5;
    localparam int CB_ERRIE = 6;
    localparam int CB_RTO   = 7;
    localparam int CB_RXT   = 8;
    localparam int CB_TXT   = 9;
    localparam int TICKS_PER_CHAR = 160;
endpackage

// File: rtl/uch_fifo.sv
module uch_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk)
        if (push) mem[wp] <= din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rp];

    // R13: occupancy never exceeds the configured depth
    a_r13_count_bound: assert property (@(posedge clk) disable iff (!rst_n) count <= FULLC);
    // R9: the owner never pushes into a full FIFO
    a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && count == FULLC));
endmodule

// File: rtl/uch_tx.sv
module uch_tx import uart_chan_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       have_data,
    input  logic [7:0] din,
    input  logic       brk_req,
    output logic       pop,
    output logic       brk_done,
    output logic       txd,
    output logic       busy
);
    tx_st_e     st;
    logic [3:0] tcnt;
    logic [3:0] bitn;
    logic [7:0] sh;
    logic       bit_end;

    assign bit_end = tick && (tcnt == 4'd15);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= T_IDLE;
            tcnt <= '0;
            bitn <= '0;
            sh   <= '0;
        end else begin
            if (st == T_IDLE) tcnt <= '0;
            else if (tick)    tcnt <= tcnt + 1'b1;
            unique case (st)
                T_IDLE: begin
                    bitn <= '0;
                    if (brk_req) st <= T_BREAK;
                    else if (have_data) begin
                        sh <= din;
                        st <= T_START;
                    end
                end
                T_START: if (bit_end) st <= T_DATA;
                T_DATA: if (bit_end) begin
                    sh   <= sh >> 1;
                    bitn <= bitn + 1'b1;
                    if (bitn == 4'd7) st <= T_STOP;
                end
                T_STOP: if (bit_end) st <= T_IDLE;
                T_BREAK: if (bit_end) begin
                    bitn <= bitn + 1'b1;
                    if (bitn == 4'd9) st <= T_IDLE;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    always_comb begin
        pop      = (st == T_IDLE) && !brk_req && have_data;
        brk_done = (st == T_BREAK) && bit_end && (bitn == 4'd9);
        busy     = (st != T_IDLE);
        unique case (st)
            T_START, T_BREAK: txd = 1'b0;
            T_DATA:           txd = sh[0];
            default:          txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uch_rx.sv
module uch_rx import uart_chan_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    output logic       done,
    output logic       ferr,
    output logic       brk,
    output logic [7:0] data
);
    rx_st_e     st;
    logic [3:0] tcnt;
    logic [2:0] bitn;
    logic       stop_samp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= R_IDLE;
            tcnt <= '0;
            bitn <= '0;
            data <= '0;
        end else begin
            if (tick) tcnt <= tcnt + 1'b1;
            unique case (st)
                R_IDLE: begin
                    tcnt <= '0;
                    if (tick && !rxd) st <= R_START;
                end
                R_START: if (tick && tcnt == 4'd7) begin
                    tcnt <= '0;
                    bitn <= '0;
                    st   <= rxd ? R_IDLE : R_DATA;
                end
                R_DATA: if (tick && tcnt == 4'd15) begin
                    data <= {rxd, data[7:1]};
                    bitn <= bitn + 1'b1;
                    if (bitn == 3'd7) st <= R_STOP;
                end
                R_STOP: if (tick && tcnt == 4'd15) st <= rxd ? R_IDLE : R_WAITHI;
                R_WAITHI: if (tick && rxd) st <= R_IDLE;
                default: st <= R_IDLE;
            endcase
        end
    end

    always_comb begin
        stop_samp = (st == R_STOP) && tick && (tcnt == 4'd15);
        done      = stop_samp && rxd;
        brk       = stop_samp && !rxd && (data == 8'h00);
        ferr      = stop_samp && !rxd && (data != 8'h00);
    end
endmodule

// File: rtl/uart_chan.sv
module uart_chan import uart_chan_pkg::*; #(
    parameter int DEPTH    = 16,
    parameter int TX_TRIG  = 4,
    parameter int RX_TRIG  = 8,
    parameter int TO_CHARS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pclk_en,
    input  logic        ext_en,
    input  logic        pll_en,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic [1:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    input  logic        rx_i,
    output logic        tx_o,
    output logic        tx_irq_o,
    output logic        rx_irq_o,
    output logic        err_irq_o
);
    localparam int CW  = $clog2(DEPTH+1);
    localparam int TOT_I = TO_CHARS * TICKS_PER_CHAR;
    localparam int TOW = $clog2(TOT_I+1);
    localparam logic [CW-1:0]  FULLC = CW'(DEPTH);
    localparam logic [CW-1:0]  TXT   = CW'(TX_TRIG);
    localparam logic [CW-1:0]  RXT   = CW'(RX_TRIG);
    localparam logic [TOW-1:0] TOT   = TOW'(TOT_I);

    logic [11:0] ctrl;
    logic [15:0] div, bcnt;
    logic        src_tick, tick, fifo_en;
    logic        rxs1, rxs2, s_txd, rx_line;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [7:0]  tx_dout, rx_dout, rx_data;
    logic        tx_push, tx_pop, tx_full, tx_busy, brk_done;
    logic        rx_push, rx_pop, rx_full, rx_done, rx_ferr, rx_brk;
    logic        ovr_f, fe_f, bk_f, stat_rd;
    logic        tx_cond, tx_cond_q, rx_cond, rx_cond_q;
    logic [TOW-1:0] to_cnt;
    logic        to_run, rto, rto_q;

    assign fifo_en = ctrl[CB_FIFO];
    always_comb begin
        unique case (ctrl[11:10])
            2'b01:   src_tick = ext_en;
            2'b11:   src_tick = pll_en;
            default: src_tick = pclk_en;
        endcase
    end
    assign tick = src_tick && (bcnt >= div);

    assign stat_rd = rd_i && (addr_i == A_STAT);
    assign tx_full = fifo_en ? (tx_cnt == FULLC) : (tx_cnt != '0);
    assign rx_full = fifo_en ? (rx_cnt == FULLC) : (rx_cnt != '0);
    assign tx_push = wr_i && (addr_i == A_DATA) && !tx_full;
    assign rx_push = rx_done && !rx_full;
    assign rx_pop  = rd_i && (addr_i == A_DATA) && (rx_cnt != '0);
    assign tx_cond = fifo_en ? (tx_cnt <= TXT) : (tx_cnt == '0);
    assign rx_cond = fifo_en ? (rx_cnt >= RXT) : (rx_cnt != '0);
    assign to_run  = fifo_en && ctrl[CB_RTO] && (rx_cnt != '0);
    assign rx_line = ctrl[CB_LOOP] ? s_txd : rxs2;
    assign tx_o    = ctrl[CB_LOOP] ? 1'b1 : s_txd;

    uch_fifo #(.W(8), .DEPTH(DEPTH)) u_txf (.clk(clk), .rst_n(rst_n), .push(tx_push),
        .din(wdata_i[7:0]), .pop(tx_pop), .dout(tx_dout), .count(tx_cnt));
    uch_fifo #(.W(8), .DEPTH(DEPTH)) u_rxf (.clk(clk), .rst_n(rst_n), .push(rx_push),
        .din(rx_data), .pop(rx_pop), .dout(rx_dout), .count(rx_cnt));
    uch_tx u_tx (.clk(clk), .rst_n(rst_n), .tick(tick), .have_data(tx_cnt != '0),
        .din(tx_dout), .brk_req(ctrl[CB_BRK]), .pop(tx_pop), .brk_done(brk_done),
        .txd(s_txd), .busy(tx_busy));
    uch_rx u_rx (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rx_line), .done(rx_done),
        .ferr(rx_ferr), .brk(rx_brk), .data(rx_data));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;  div <= '0;  bcnt <= '0;
            rxs1 <= 1'b1; rxs2 <= 1'b1;
            ovr_f <= 1'b0; fe_f <= 1'b0; bk_f <= 1'b0;
            to_cnt <= '0; rto <= 1'b0; rto_q <= 1'b0;
            tx_cond_q <= 1'b1; rx_cond_q <= 1'b0;
            tx_irq_o <= 1'b0; rx_irq_o <= 1'b0; err_irq_o <= 1'b0;
            rdata_o <= '0;
        end else begin
            rxs1 <= rx_i;
            rxs2 <= rxs1;
            if (src_tick) bcnt <= (bcnt >= div) ? '0 : bcnt + 1'b1;
            if (brk_done) ctrl[CB_BRK] <= 1'b0;
            if (wr_i && addr_i == A_CTRL) ctrl <= wdata_i[11:0];
            if (wr_i && addr_i == A_DIV)  div  <= wdata_i;
            ovr_f <= (rx_done && rx_full) || (ovr_f && !stat_rd);
            fe_f  <= rx_ferr || (fe_f && !stat_rd);
            bk_f  <= rx_brk  || (bk_f && !stat_rd);
            if (!to_run || rx_push || rx_pop) to_cnt <= '0;
            else if (tick && to_cnt != TOT)   to_cnt <= to_cnt + 1'b1;
            if (!to_run || rx_pop)  rto <= 1'b0;
            else if (to_cnt == TOT) rto <= 1'b1;
            rto_q     <= rto;
            tx_cond_q <= tx_cond;
            rx_cond_q <= rx_cond;
            tx_irq_o  <= ctrl[CB_TXT] ? tx_cond : (tx_cond && !tx_cond_q);
            rx_irq_o  <= ctrl[CB_RXT] ? (rx_cond || rto)
                                      : ((rx_cond && !rx_cond_q) || (rto && !rto_q));
            err_irq_o <= ctrl[CB_ERRIE] && ((rx_done && rx_full) || rx_ferr || rx_brk);
            if (rd_i) begin
                unique case (addr_i)
                    A_CTRL:  rdata_o <= {4'b0, ctrl};
                    A_DIV:   rdata_o <= div;
                    A_DATA:  rdata_o <= {8'b0, rx_dout};
                    default: rdata_o <= {11'b0, bk_f, fe_f, ovr_f,
                                         (tx_cnt == '0) && !tx_busy, rx_cnt != '0};
                endcase
            end
        end
    end

    // R5: pulse-style transmit interrupt lasts a single cycle
    a_r5_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CB_TXT] && tx_irq_o) |=> (!tx_irq_o || ctrl[CB_TXT]));
    // R6: pulse-style receive interrupt lasts a single cycle
    a_r6_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CB_RXT] && rx_irq_o) |=> (!rx_irq_o || ctrl[CB_RXT]));
    // R9: a character arriving into a full buffer leaves the overrun flag set
    a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_full) |=> ovr_f);
    // R12: the send-break bit clears itself when the break frame ends
    a_r12_brk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_done && !(wr_i && addr_i == A_CTRL)) |=> !ctrl[CB_BRK]);
endmodule

// File: tb/uart_chan_bench.sv
`timescale 1ns/1ps
module uart_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pclk_en = 1'b1, ext_en = 1'b0, pll_en = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rx_i = 1'b1;
    logic        tx_o, tx_irq, rx_irq, err_irq;

    int checks = 0, fails = 0, mchecks = 0, mfails = 0;
    int bit_cyc = 16;
    logic mon_en = 1'b1;
    logic [7:0] exp_q[$];
    int txirq_n = 0, rxirq_n = 0, errirq_n = 0, txlow_n = 0;

    always #2 clk = ~clk;

    uart_chan #(.DEPTH(4), .TX_TRIG(1), .RX_TRIG(2), .TO_CHARS(3)) u_uart_chan (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .ext_en(ext_en), .pll_en(pll_en),
        .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .rx_i(rx_i), .tx_o(tx_o), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .err_irq_o(err_irq));

    always @(negedge clk) begin
        if (tx_irq)  txirq_n  <= txirq_n + 1;
        if (rx_irq)  rxirq_n  <= rxirq_n + 1;
        if (err_irq) errirq_n <= errirq_n + 1;
        if (!tx_o)   txlow_n  <= txlow_n + 1;
    end

    // monitor: decode frames on tx_o and compare with the scoreboard queue (R3)
    initial begin
        logic [7:0] got;
        logic ok;
        forever begin
            @(negedge clk);
            if (mon_en && !tx_o) begin
                ok = 1'b1;
                repeat (bit_cyc/2) @(negedge clk);
                if (tx_o) ok = 1'b0;
                for (int i = 0; i < 8; i++) begin
                    repeat (bit_cyc) @(negedge clk);
                    got[i] = tx_o;
                end
                repeat (bit_cyc) @(negedge clk);
                if (!tx_o) ok = 1'b0;
                mchecks++;
                if (exp_q.size() == 0) begin
                    mfails++;
                    $display("FAIL R3: unexpected frame got %h expected none", got);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (!ok || got !== e) begin
                        mfails++;
                        $display("FAIL R3: frame got %h (framing ok=%0d) expected %h", got, ok, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL R1: watchdog expired, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks + 1, fails + mfails + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic send_tx(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        reg_wr(2'd2, {8'h00, b});
        for (int i = 0; i < 12*bit_cyc + 60 && exp_q.size() != 0; i++) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: character %h got not sent expected sent", tag, b);
            exp_q.delete();
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        rx_i = 1'b0; repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rx_i = b[i]; repeat (16) @(negedge clk); end
        rx_i = stop; repeat (16) @(negedge clk);
        rx_i = 1'b1; repeat (20) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        int base, base2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 tx idle", {15'b0, tx_o}, 16'h0001);
        chk("R1 irqs", {13'b0, tx_irq, rx_irq, err_irq}, 16'h0000);
        reg_rd(2'd0, d); chk("R1 ctrl", d, 16'h0000);
        reg_rd(2'd3, d); chk("R1 stat", d, 16'h0002);

        // R3 framing in FIFO mode, peripheral clock
        reg_wr(2'd1, 16'h0000);
        reg_wr(2'd0, 16'h0001);
        send_tx(8'hA5, "R3");
        send_tx(8'h3C, "R3");
        // R2 clock source selection
        reg_wr(2'd0, 16'h0801); send_tx(8'h5A, "R2 sel10");
        pclk_en = 1'b0; ext_en = 1'b1;
        reg_wr(2'd0, 16'h0401); send_tx(8'hC3, "R2 sel01");
        ext_en = 1'b0; pll_en = 1'b1;
        reg_wr(2'd1, 16'h0001); bit_cyc = 32;
        reg_wr(2'd0, 16'h0C01); send_tx(8'h81, "R2 sel11 div1");
        reg_wr(2'd0, 16'h0000); reg_wr(2'd1, 16'h0000);
        pll_en = 1'b0; pclk_en = 1'b1; bit_cyc = 16;
        repeat (40) @(negedge clk);

        // R5 transmit interrupt, pulse then level
        base = txirq_n;
        send_tx(8'h55, "R5");
        repeat (20) @(negedge clk);
        chk("R5 pulse count", 16'(txirq_n - base), 16'd1);
        reg_wr(2'd0, 16'h0200);
        repeat (3) @(negedge clk);
        chk("R5 level", {15'b0, tx_irq}, 16'h0001);
        reg_wr(2'd0, 16'h0000);

        // R4/R6 non-FIFO receive
        base = rxirq_n;
        send_rx(8'h96, 1'b1);
        chk("R6 nonfifo pulse", 16'(rxirq_n - base), 16'd1);
        reg_rd(2'd2, d); chk("R4 data", d, 16'h0096);

        // R6 FIFO trigger at 2
        reg_wr(2'd0, 16'h0001);
        base = rxirq_n;
        send_rx(8'h11, 1'b1);
        chk("R6 below trigger", 16'(rxirq_n - base), 16'd0);
        send_rx(8'h22, 1'b1);
        chk("R6 at trigger", 16'(rxirq_n - base), 16'd1);
        reg_rd(2'd2, d); chk("R4 order first", d, 16'h0011);
        reg_rd(2'd2, d); chk("R4 order second", d, 16'h0022);

        // R7 receive time-out
        reg_wr(2'd0, 16'h0081);
        base = rxirq_n;
        send_rx(8'h33, 1'b1);
        chk("R7 not yet", 16'(rxirq_n - base), 16'd0);
        repeat (560) @(negedge clk);
        chk("R7 timeout fired", 16'(rxirq_n - base), 16'd1);
        reg_rd(2'd2, d); chk("R7 data", d, 16'h0033);
        reg_wr(2'd0, 16'h0080);
        base = rxirq_n;
        send_rx(8'h44, 1'b1);
        repeat (600) @(negedge clk);
        chk("R7 ignored nonfifo", 16'(rxirq_n - base), 16'd1);
        reg_rd(2'd2, d);

        // R9/R8 overrun in FIFO mode
        reg_wr(2'd0, 16'h0041);
        base = errirq_n;
        for (int i = 1; i <= 5; i++) send_rx(8'(i), 1'b1);
        chk("R8 overrun irq", 16'(errirq_n - base), 16'd1);
        reg_rd(2'd3, d); chk("R9 overrun set", d, 16'h0007);
        reg_rd(2'd3, d); chk("R9 overrun cleared", d, 16'h0003);
        for (int i = 1; i <= 4; i++) begin
            reg_rd(2'd2, d); chk("R9 kept data", d, 16'(i));
        end

        // R13 non-FIFO holds one character
        reg_wr(2'd0, 16'h0040);
        send_rx(8'h61, 1'b1);
        send_rx(8'h62, 1'b1);
        reg_rd(2'd3, d); chk("R13 single buffer overrun", d, 16'h0007);
        reg_rd(2'd2, d); chk("R13 first kept", d, 16'h0061);

        // R8 framing error
        base = errirq_n;
        send_rx(8'h7E, 1'b0);
        chk("R8 frame irq", 16'(errirq_n - base), 16'd1);
        reg_rd(2'd3, d); chk("R8 frame flag", d, 16'h000A);

        // R10 break detection
        base = errirq_n;
        rx_i = 1'b0; repeat (192) @(negedge clk);
        rx_i = 1'b1; repeat (40) @(negedge clk);
        chk("R10 break irq", 16'(errirq_n - base), 16'd1);
        reg_rd(2'd3, d); chk("R10 break flag", d, 16'h0012);

        // R11 loopback
        mon_en = 1'b0;
        reg_wr(2'd0, 16'h0021);
        rx_i = 1'b0;
        base2 = txlow_n;
        reg_wr(2'd2, 16'h00B7);
        repeat (220) @(negedge clk);
        chk("R11 pin idle", 16'(txlow_n - base2), 16'd0);
        reg_rd(2'd2, d); chk("R11 looped data", d, 16'h00B7);
        rx_i = 1'b1;
        repeat (40) @(negedge clk);

        // R12 send break
        base2 = txlow_n;
        reg_wr(2'd0, 16'h0010);
        repeat (220) @(negedge clk);
        chk("R12 break length", 16'(txlow_n - base2), 16'd160);
        reg_rd(2'd0, d); chk("R12 auto clear", d, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks, fails + mfails);
        $finish;
    end
endmodule